// File: doc/BRIEF.md
# Programmable resolution watchdog timer

This block is a one-shot watchdog whose whole configuration fits in a single byte. A write of that byte both sets the timeout and starts the countdown. The timeout is a 5-bit multiplier times one of four resolutions, which go up in powers of four from 1/16 s to 4 s. One further bit decides what happens on expiry: either a reset pulse of fixed length or an interrupt level that stays up until software writes the byte again.

Time is kept in base ticks of 1/16 s. Those ticks come either from an external strobe, with one counted tick for each clock cycle in which the strobe is high, or from an internal prescaler that divides the system clock by a parameter. Software keeps the system alive by writing the byte again before the count runs out. Writing a multiplier of zero stops the watchdog.

Top module: `wdt_prog_res`

## Requirements
- R1: After reset both `wdt_rst_o` and `wdt_irq_o` are low and the watchdog is disarmed, so no output rises until a write with a nonzero multiplier.
- R2: The byte is decoded as steer = bit 7, multiplier M = bits [6:2] and resolution code S = bits [1:0]. The timeout is T = M × 4^S base ticks, so S = 0, 1, 2, 3 gives steps of 1, 4, 16 and 64 ticks. The output changes at the clock edge of the T-th counted tick after the write, and not one tick earlier.
- R3: When bit 7 is 1, expiry drives `wdt_rst_o` only. When bit 7 is 0, expiry drives `wdt_irq_o` only.
- R4: A write with M = 0 disarms the watchdog. No output rises afterwards, however many ticks arrive.
- R5: Every write reloads the countdown with its own period and restarts timing from that write's clock edge. A tick that falls in the same cycle as the write is not counted. A rewrite in the middle of a count therefore postpones expiry.
- R6: On expiry with bit 7 = 1, `wdt_rst_o` is high for exactly RST_PULSE_LEN clock cycles.
- R7: On expiry with bit 7 = 0, `wdt_irq_o` rises and stays high until the next write. That write clears it at its own clock edge.
- R8: Expiry fires once. Ticks that arrive after it produce no further output until the byte is written again.
- R9: With USE_EXT_TICK = 1, only cycles with `tick_in` high are counted. With USE_EXT_TICK = 0, a tick occurs every PRESCALE clocks counted from the last write, and `tick_in` is ignored.
- R10: The shortest timeout is 1 tick (M = 1, S = 0), which is 62.5 ms. The longest is 1984 ticks (M = 31, S = 3), which is 124 s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration byte; arms or re-arms the watchdog |
| cfg_data | input | 8 | Configuration byte: steer bit, multiplier, resolution code |
| tick_in | input | 1 | External 1/16 s tick strobe; counted only when USE_EXT_TICK = 1 |
| wdt_rst_o | output | 1 | Reset pulse on expiry when the steer bit is 1 |
| wdt_irq_o | output | 1 | Interrupt level on expiry when the steer bit is 0; cleared by a write |

## Verification
The main instance uses the external tick with RST_PULSE_LEN = 3. Holding `tick_in` high gives one tick per clock, so all 124 combinations of nonzero multiplier and resolution, up to the 1984-tick maximum, fit in a single sweep that checks the edge before expiry and the expiry edge itself. A second instance with USE_EXT_TICK = 0, PRESCALE = 3 and RST_PULSE_LEN = 2 is small enough that the prescaled arithmetic (T × 3 clocks) can be checked cycle by cycle while a toggling `tick_in` shows it has no effect. Sparse tick patterns, mid-count rewrites, disarm writes and the one-shot rule are also driven against the main instance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int RES_W         = 2;
   localparam int MULT_W        = 5;
   localparam int CFG_W         = 8;
   localparam int RES_STEP_LOG2 = 2;
   localparam int MAX_TICKS     = ((1 << MULT_W) - 1) << (RES_STEP_LOG2 * ((1 << RES_W) - 1));
   localparam int CNT_W         = $clog2(MAX_TICKS + 1);

   typedef struct packed {
      logic              steer_rst;
      logic [MULT_W-1:0] mult;
      logic [RES_W-1:0]  res;
   } wdt_cfg_t;

   function automatic logic [CNT_W-1:0] period_ticks(input wdt_cfg_t c);
      logic [CNT_W-1:0] m;
      m = CNT_W'(c.mult);
      return m << (RES_STEP_LOG2 * int'(c.res));
   endfunction
endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src #(
   parameter bit USE_EXT_TICK = 1'b1,
   parameter int PRESCALE     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick_in,
   output logic tick
);
   localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   generate
      if (USE_EXT_TICK) begin : g_ext
         assign tick = tick_in;
      end else begin : g_div
         logic [PS_W-1:0] pcnt;
         logic            unused_tick_in;
         logic            at_end;
         assign unused_tick_in = tick_in;
         assign at_end = (pcnt == PS_W'(PRESCALE - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pcnt <= '0;
            else if (restart) pcnt <= '0;
            else if (at_end)  pcnt <= '0;
            else              pcnt <= pcnt + PS_W'(1);
         end
         assign tick = at_end;
      end
   endgenerate
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_ticks,
   input  logic             tick,
   output logic             expire
);
   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic             last_tick;

   assign last_tick = (cnt == CNT_W'(1));
   assign expire    = !load && tick && armed && last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (load) begin
         cnt   <= load_ticks;
         armed <= (load_ticks != '0);
      end else if (tick && armed) begin
         if (last_tick) begin
            cnt   <= '0;
            armed <= 1'b0;
         end else begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/wdt_fire_out.sv
module wdt_fire_out #(
   parameter int PULSE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_irq,
   input  logic expire,
   input  logic steer_rst,
   output logic rst_o,
   output logic irq_o
);
   localparam int PL_W = $clog2(PULSE_LEN + 1);

   logic fire_rst;
   logic fire_irq;
   assign fire_rst = expire && steer_rst;
   assign fire_irq = expire && !steer_rst;

   generate
      if (PULSE_LEN == 1) begin : g_single
         logic rst_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= fire_rst;
         end
         assign rst_o = rst_q;
      end else begin : g_stretch
         logic [PL_W-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           pcnt <= '0;
            else if (fire_rst)    pcnt <= PL_W'(PULSE_LEN);
            else if (pcnt != '0)  pcnt <= pcnt - PL_W'(1);
         end
         assign rst_o = (pcnt != '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irq_o <= 1'b0;
      else if (clear_irq) irq_o <= 1'b0;
      else if (fire_irq)  irq_o <= 1'b1;
   end
endmodule

// File: rtl/wdt_prog_res.sv
module wdt_prog_res
   import wdt_pkg::*;
#(
   parameter bit USE_EXT_TICK  = 1'b1,
   parameter int PRESCALE      = 1,
   parameter int RST_PULSE_LEN = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_wr,
   input  logic [7:0] cfg_data,
   input  logic       tick_in,
   output logic       wdt_rst_o,
   output logic       wdt_irq_o
);
   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("wdt_prog_res: PRESCALE must be at least 1");
      end
      if (RST_PULSE_LEN < 1) begin : g_bad_pulse
         $error("wdt_prog_res: RST_PULSE_LEN must be at least 1");
      end
      if ($bits(wdt_cfg_t) != CFG_W) begin : g_bad_cfg
         $error("wdt_prog_res: configuration struct width mismatch");
      end
   endgenerate

   wdt_cfg_t         wr_cfg;
   logic [CNT_W-1:0] wr_ticks;
   logic             steer_q;
   logic             tick;
   logic             expire;

   assign wr_cfg   = wdt_cfg_t'(cfg_data);
   assign wr_ticks = period_ticks(wr_cfg);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      steer_q <= 1'b0;
      else if (cfg_wr) steer_q <= wr_cfg.steer_rst;
   end

   wdt_tick_src #(
      .USE_EXT_TICK(USE_EXT_TICK),
      .PRESCALE    (PRESCALE)
   ) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(cfg_wr),
      .tick_in(tick_in),
      .tick   (tick)
   );

   wdt_countdown #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_wr),
      .load_ticks(wr_ticks),
      .tick      (tick),
      .expire    (expire)
   );

   wdt_fire_out #(
      .PULSE_LEN(RST_PULSE_LEN)
   ) u_fire (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_irq(cfg_wr),
      .expire   (expire),
      .steer_rst(steer_q),
      .rst_o    (wdt_rst_o),
      .irq_o    (wdt_irq_o)
   );
endmodule

// File: rtl/wdt_prog_res_chk.sv
module wdt_prog_res_chk #(
   parameter bit USE_EXT_TICK  = 1'b1,
   parameter int RST_PULSE_LEN = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_wr,
   input logic [7:0] cfg_data,
   input logic       tick_in,
   input logic       wdt_rst_o,
   input logic       wdt_irq_o
);
   logic        steer_q;
   logic        disarm_q;
   logic [15:0] run_q;
   logic        unused_chk;
   assign unused_chk = ^{cfg_data[1:0], tick_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         steer_q  <= 1'b0;
         disarm_q <= 1'b1;
      end else if (cfg_wr) begin
         steer_q  <= cfg_data[7];
         disarm_q <= (cfg_data[6:2] == 5'd0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  run_q <= '0;
      else if (!wdt_rst_o)         run_q <= '0;
      else if (run_q != 16'hffff)  run_q <= run_q + 16'd1;
   end

   // R3: the interrupt rises only under a steer bit of 0
   a_r3_irq_steer: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_irq_o) |-> !steer_q);
   // R3: the reset pulse rises only under a steer bit of 1
   a_r3_rst_steer: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst_o) |-> steer_q);
   // R1 / R4: disarmed after reset or a zero-multiplier write
   a_r4_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      disarm_q |-> (!$rose(wdt_irq_o) && !$rose(wdt_rst_o)));
   // R7: interrupt holds until a write
   a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_irq_o && !cfg_wr) |=> wdt_irq_o);
   // R7: a write clears the interrupt
   a_r7_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> !wdt_irq_o);
   // R6: the reset pulse lasts at least the configured length
   a_r6_rst_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wdt_rst_o) |-> (run_q >= 16'(RST_PULSE_LEN)));

   generate
      if (USE_EXT_TICK) begin : g_ext_chk
         // R9: with an external tick, an output rises only after a counted tick
         a_r9_tick_cause: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(wdt_irq_o) || $rose(wdt_rst_o)) |-> $past(tick_in));
      end
   endgenerate
endmodule

bind wdt_prog_res wdt_prog_res_chk #(
   .USE_EXT_TICK (USE_EXT_TICK),
   .RST_PULSE_LEN(RST_PULSE_LEN)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_wr   (cfg_wr),
   .cfg_data (cfg_data),
   .tick_in  (tick_in),
   .wdt_rst_o(wdt_rst_o),
   .wdt_irq_o(wdt_irq_o)
);

// File: tb/wdt_prog_res_tb.sv
`timescale 1ns/1ps
module wdt_prog_res_tb;
   localparam int PULSE_A = 3;
   localparam int PULSE_B = 2;
   localparam int PS_B    = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_a = 1'b0, wr_b = 1'b0;
   logic [7:0] d_a = '0, d_b = '0;
   logic       tick = 1'b0;
   logic       rst_a, irq_a, rst_b, irq_b;

   int n_chk = 0;
   int n_bad = 0;
   bit ended = 0;

   always #4 clk = ~clk;

   wdt_prog_res #(.USE_EXT_TICK(1'b1), .PRESCALE(1), .RST_PULSE_LEN(PULSE_A)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr_a), .cfg_data(d_a), .tick_in(tick),
      .wdt_rst_o(rst_a), .wdt_irq_o(irq_a));

   wdt_prog_res #(.USE_EXT_TICK(1'b0), .PRESCALE(PS_B), .RST_PULSE_LEN(PULSE_B)) u_dut_pre (
      .clk(clk), .rst_n(rst_n), .cfg_wr(wr_b), .cfg_data(d_b), .tick_in(tick),
      .wdt_rst_o(rst_b), .wdt_irq_o(irq_b));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic write_a(input logic [7:0] d);
      @(negedge clk); wr_a = 1'b1; d_a = d;
      @(negedge clk); wr_a = 1'b0;
   endtask

   task automatic write_b(input logic [7:0] d);
      @(negedge clk); wr_b = 1'b1; d_b = d;
      @(negedge clk); wr_b = 1'b0;
   endtask

   function automatic logic [7:0] cfg(input int steer, input int m, input int s);
      return {steer[0], m[4:0], s[1:0]};
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int len;
      int bad;
      repeat (4) @(negedge clk);
      check("R1 reset rst_a", int'(rst_a), 0);
      check("R1 reset irq_a", int'(irq_a), 0);
      check("R1 reset rst_b", int'(rst_b), 0);
      check("R1 reset irq_b", int'(irq_b), 0);
      rst_n = 1'b1;
      tick = 1'b1;
      repeat (20) @(negedge clk);
      check("R1 no fire before write", int'(rst_a | irq_a), 0);

      // R4: zero multiplier, both steer values
      write_a(cfg(1, 0, 3));
      repeat (300) @(negedge clk);
      check("R4 disarm rst", int'(rst_a | irq_a), 0);
      write_a(cfg(0, 0, 1));
      repeat (300) @(negedge clk);
      check("R4 disarm irq", int'(rst_a | irq_a), 0);

      // R2 R3 R6 R7 R10: full sweep, one tick per cycle
      for (int s = 0; s < 4; s++) begin
         for (int m = 1; m < 32; m++) begin
            int t;
            int st;
            t  = m << (2 * s);
            st = (m + s) % 2;
            write_a(cfg(st, m, s));
            check("R7 write clears irq", int'(irq_a), 0);
            repeat (t - 1) @(negedge clk);
            check("R2 quiet before expiry", int'(rst_a | irq_a), 0);
            @(negedge clk);
            if (t == 1 || t == 1984)
               check("R10 boundary expiry", int'(rst_a | irq_a), 1);
            if (st == 1) begin
               check("R3 rst on steer 1", int'(rst_a), 1);
               check("R3 irq quiet on steer 1", int'(irq_a), 0);
               len = 0;
               while (rst_a && len < 100) begin
                  len++;
                  @(negedge clk);
               end
               check("R6 pulse length", len, PULSE_A);
            end else begin
               check("R3 irq on steer 0", int'(irq_a), 1);
               check("R3 rst quiet on steer 0", int'(rst_a), 0);
               repeat (5) @(negedge clk);
               check("R7 irq holds", int'(irq_a), 1);
            end
         end
      end

      // R8: one-shot
      write_a(cfg(1, 2, 0));
      repeat (2 + PULSE_A) @(negedge clk);
      bad = 0;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (rst_a || irq_a) bad++;
      end
      check("R8 no refire", bad, 0);

      // R5: rewrite mid-count postpones expiry
      write_a(cfg(0, 4, 1));
      repeat (10) @(negedge clk);
      write_a(cfg(0, 4, 1));
      repeat (15) @(negedge clk);
      check("R5 rearm postpones", int'(irq_a), 0);
      @(negedge clk);
      check("R5 rearm expiry", int'(irq_a), 1);
      write_a(cfg(1, 4, 1));
      repeat (5) @(negedge clk);
      write_a(cfg(1, 0, 0));
      repeat (50) @(negedge clk);
      check("R5 R4 rewrite zero stops", int'(rst_a | irq_a), 0);

      // R9: sparse external ticks
      tick = 1'b0;
      write_a(cfg(1, 3, 0));
      repeat (4) @(negedge clk);
      check("R9 no ticks no count", int'(rst_a), 0);
      for (int k = 1; k <= 3; k++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         check("R9 sparse ticks", int'(rst_a), (k == 3) ? 1 : 0);
         @(negedge clk);
      end
      repeat (PULSE_A + 2) @(negedge clk);

      // R9: prescaled instance, tick_in toggling and ignored
      fork
         begin
            for (int k = 0; k < 60; k++) begin
               @(negedge clk); tick = ~tick;
            end
         end
         begin
            write_b(cfg(0, 2, 1));
            repeat (8 * PS_B - 1) @(negedge clk);
            check("R9 prescale quiet", int'(irq_b), 0);
            @(negedge clk);
            check("R9 prescale expiry irq", int'(irq_b), 1);
         end
      join
      write_b(cfg(1, 1, 1));
      check("R7 prescale irq cleared", int'(irq_b), 0);
      repeat (4 * PS_B - 1) @(negedge clk);
      check("R9 prescale quiet rst", int'(rst_b), 0);
      @(negedge clk);
      check("R9 prescale expiry rst", int'(rst_b), 1);
      len = 0;
      while (rst_b && len < 100) begin
         len++;
         @(negedge clk);
      end
      check("R6 prescale pulse length", len, PULSE_B);

      finish_run();
   end
endmodule